// File: doc/BRIEF.md
# Synchronous FIFO Controller with Selectable Fall-Through Output

This block is a single-clock first-in first-out queue. It keeps its own storage array, advances its write and read positions by itself, and takes only a write strobe and a read strobe from the user. Both data ports have the same width. The depth is set by a parameter. Four status outputs tell the user how full the queue is. Two of them, the near-full and near-empty warnings, compare the occupancy against offsets that can be changed while the block runs.

A mode input picks how read data is presented. In registered mode, an accepted read loads the oldest word into an output register, so the word is seen one cycle after the request. In fall-through mode, the oldest stored word is already on the output while the queue is not empty, and a read moves the output on to the next word. An attempt to write into a full queue, or to read from an empty one, is dropped. Each such attempt sets a sticky error output, which stays set until reset.

Top module: `fifo_fwft_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) empties the queue. After the reset edge, empty=1, almost_empty=1, full=0, overflow=0, underflow=0 and the registered output word is 0. almost_full=0 also holds whenever af_level is below DEPTH.
- R2: empty=1 exactly when zero words are stored, and full=1 exactly when DEPTH words are stored. A write with wr_en=1 while not full stores wr_data and adds one word.
- R3: With fwft_en=0, words leave in the order they were written. An accepted read loads the oldest word into rd_data at that clock edge. rd_data holds its value on every other cycle.
- R4: With fwft_en=1, rd_data shows the oldest stored word with no read request, and empty falls at the same edge that stores the first word. An accepted read makes the next word visible after that edge.
- R5: A write while full is dropped and sets overflow. A read while empty is dropped and sets underflow. Both outputs stay at 1 until reset.
- R6: A read and a write in the same cycle, while the queue is neither empty nor full, leave the occupancy unchanged.
- R7: almost_full=1 exactly when occupancy + af_level >= DEPTH. af_level can be changed at any time, and the output follows it without delay.
- R8: almost_empty=1 exactly when occupancy <= ae_level. ae_level can be changed at any time, and the output follows it without delay.
- R9: A read and a write in the same cycle while full perform only the read, and set overflow. A read and a write in the same cycle while empty perform only the write, and set underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fwft_en | input | 1 | 1 selects fall-through output, 0 selects registered output |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Output word |
| af_level | input | $clog2(DEPTH+1) | Offset below DEPTH at which almost_full rises |
| ae_level | input | $clog2(DEPTH+1) | Occupancy at or below which almost_empty is high |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| almost_full | output | 1 | Near-full warning |
| almost_empty | output | 1 | Near-empty warning |
| overflow | output | 1 | Sticky flag: a write was dropped |
| underflow | output | 1 | Sticky flag: a read was dropped |

## Verification
The assertions assume that rst is held for at least one edge before any checked behaviour. They also assume that fwft_en changes only while the queue is empty, because a mode change with words in flight has no defined output word. The stimulus follows both assumptions: it switches the mode only while reset is asserted, and it changes the threshold offsets only between strobes. Under those conditions, the checks on occupancy stepping, the sticky error outputs and the reset state hold for every strobe pattern.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic {
        RD_REGISTERED  = 1'b0,
        RD_FALLTHROUGH = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rword = cells[raddr];
endmodule

// File: rtl/fifo_thresh.sv
module fifo_thresh #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] af_level,
    input  logic [CW-1:0] ae_level,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);
    logic [CW:0] occ_plus_af;

    always_comb begin
        occ_plus_af  = {1'b0, occ} + {1'b0, af_level};
        full         = (occ == CW'(DEPTH));
        empty        = (occ == '0);
        almost_full  = (occ_plus_af >= (CW+1)'(DEPTH));
        almost_empty = (occ <= ae_level);
    end
endmodule

// File: rtl/fifo_fwft_ctrl.sv
module fifo_fwft_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwft_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CW-1:0]     af_level,
    input  logic [CW-1:0]     ae_level,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              overflow,
    output logic              underflow
);
    import fifo_pkg::*;

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] dout;
        logic              ovf;
        logic              udf;
    } ctrl_t;

    ctrl_t             st_d, st_q;
    rd_mode_e          mode;
    logic              wr_ok, rd_ok;
    logic [DATA_W-1:0] head_word;
    logic [CW-1:0]     occ;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign mode = rd_mode_e'(fwft_en);
    assign occ  = st_q.cnt;

    fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (st_q.wptr),
        .wdata (wr_data),
        .raddr (st_q.rptr),
        .rword (head_word)
    );

    fifo_thresh #(.DEPTH(DEPTH)) u_thresh (
        .occ          (occ),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    always_comb begin
        wr_ok = wr_en && !full;
        rd_ok = rd_en && !empty;
        st_d  = st_q;
        if (wr_ok) begin
            st_d.wptr = ptr_next(st_q.wptr);
        end
        if (rd_ok) begin
            st_d.rptr = ptr_next(st_q.rptr);
            st_d.dout = head_word;
        end
        case ({wr_ok, rd_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.ovf = st_q.ovf || (wr_en && full);
        st_d.udf = st_q.udf || (rd_en && empty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = (mode == RD_FALLTHROUGH) ? head_word : st_q.dout;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.udf;
endmodule

// File: rtl/fifo_fwft_ctrl_chk.sv
module fifo_fwft_ctrl_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic          almost_empty,
    input logic          overflow,
    input logic          underflow,
    input logic [CW-1:0] occ
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (empty && almost_empty && !full && !overflow && !underflow)); // R1

    AST_OCC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (occ <= CW'(DEPTH)) && !(full && empty)); // R2

    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !full) |=> (occ == $past(occ) + CW'(1))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && full) |=> (full && overflow && $stable(occ))); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && empty) |=> (empty && underflow)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R5

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow); // R5

    AST_RW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> $stable(occ)); // R6

    AST_FULL_RW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && full) |=> (overflow && occ == $past(occ) - CW'(1))); // R9
endmodule

bind fifo_fwft_ctrl fifo_fwft_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .full         (full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .overflow     (overflow),
    .underflow    (underflow),
    .occ          (occ)
);

// File: tb/fifo_fwft_ctrl_test.sv
module fifo_fwft_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NVEC   = 22;

    // wr, rd, din, {empty, full, almost_full, almost_empty, overflow, underflow}, rd_data
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] din;
        logic       e;
        logic       f;
        logic       af;
        logic       ae;
        logic       ov;
        logic       ud;
        logic [7:0] dout;
    } vec_t;

    // registered mode, af_level=2, ae_level=1
    localparam vec_t VEC [NVEC] = '{
        {1'b1, 1'b0, 8'h11, 6'b000100, 8'h00},
        {1'b1, 1'b0, 8'h22, 6'b000000, 8'h00},
        {1'b0, 1'b1, 8'h00, 6'b000100, 8'h11},
        {1'b1, 1'b1, 8'h33, 6'b000100, 8'h22}, // R6 read+write mid-level
        {1'b1, 1'b0, 8'h44, 6'b000000, 8'h22},
        {1'b1, 1'b0, 8'h55, 6'b000000, 8'h22},
        {1'b1, 1'b0, 8'h66, 6'b000000, 8'h22},
        {1'b1, 1'b0, 8'h77, 6'b000000, 8'h22},
        {1'b1, 1'b0, 8'h88, 6'b001000, 8'h22},
        {1'b1, 1'b0, 8'h99, 6'b001000, 8'h22},
        {1'b1, 1'b0, 8'haa, 6'b011000, 8'h22},
        {1'b1, 1'b0, 8'hbb, 6'b011010, 8'h22}, // write while full
        {1'b1, 1'b1, 8'hcc, 6'b001010, 8'h33}, // R9 read+write while full
        {1'b0, 1'b1, 8'h00, 6'b001010, 8'h44},
        {1'b0, 1'b1, 8'h00, 6'b000010, 8'h55},
        {1'b0, 1'b1, 8'h00, 6'b000010, 8'h66},
        {1'b0, 1'b1, 8'h00, 6'b000010, 8'h77},
        {1'b0, 1'b1, 8'h00, 6'b000010, 8'h88},
        {1'b0, 1'b1, 8'h00, 6'b000110, 8'h99},
        {1'b0, 1'b1, 8'h00, 6'b100110, 8'haa},
        {1'b0, 1'b1, 8'h00, 6'b100111, 8'haa}, // read while empty
        {1'b1, 1'b1, 8'hdd, 6'b000111, 8'haa}  // R9 read+write while empty
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fwft_en = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [CW-1:0]     af_level = CW'(2);
    logic [CW-1:0]     ae_level = CW'(1);
    logic [DATA_W-1:0] rd_data;
    logic full, empty, almost_full, almost_empty, overflow, underflow;

    int n_checks = 0;
    int n_errors = 0;

    fifo_fwft_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk          (clk),
        .rst          (rst),
        .fwft_en      (fwft_en),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input int idx, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s step %0d: actual=%0h expected=%0h", req, idx, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [7:0] d);
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        rst     = 1'b1;
        fwft_en = mode;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1 empty", 0, 32'(empty), 1);
        chk("R1 full", 0, 32'(full), 0);
        chk("R1 almost_empty", 0, 32'(almost_empty), 1);
        chk("R1 almost_full", 0, 32'(almost_full), 0);
        chk("R1 rd_data", 0, 32'(rd_data), 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].wr, VEC[i].rd, VEC[i].din);
            chk("R2 empty", i, 32'(empty), 32'(VEC[i].e));
            chk("R2 full", i, 32'(full), 32'(VEC[i].f));
            chk("R7 almost_full", i, 32'(almost_full), 32'(VEC[i].af));
            chk("R8 almost_empty", i, 32'(almost_empty), 32'(VEC[i].ae));
            chk("R5 overflow", i, 32'(overflow), 32'(VEC[i].ov));
            chk("R5 underflow", i, 32'(underflow), 32'(VEC[i].ud));
            chk("R3 rd_data", i, 32'(rd_data), 32'(VEC[i].dout));
        end

        // R1 reset clears sticky flags and output register
        do_reset(1'b0);
        chk("R1 overflow", 100, 32'(overflow), 0);
        chk("R1 underflow", 100, 32'(underflow), 0);
        chk("R1 empty", 100, 32'(empty), 1);
        chk("R1 rd_data", 100, 32'(rd_data), 0);

        // R6: 7 words, read+write, then one write must reach full
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 8'(8'h10 + k));
        step(1'b1, 1'b1, 8'h17);
        chk("R6 full after rw", 200, 32'(full), 0);
        chk("R6 rd_data", 200, 32'(rd_data), 32'h10);
        step(1'b1, 1'b0, 8'h18);
        chk("R6 full", 201, 32'(full), 1);

        // R7 / R8 run-time threshold changes with 4 words stored
        do_reset(1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'(8'h40 + k));
        af_level = CW'(4); #1;
        chk("R7 af at 4", 300, 32'(almost_full), 1);
        af_level = CW'(3); #1;
        chk("R7 af at 3", 301, 32'(almost_full), 0);
        ae_level = CW'(4); #1;
        chk("R8 ae at 4", 302, 32'(almost_empty), 1);
        ae_level = CW'(3); #1;
        chk("R8 ae at 3", 303, 32'(almost_empty), 0);
        af_level = CW'(2);
        ae_level = CW'(1);

        // R4 fall-through mode
        do_reset(1'b1);
        step(1'b1, 1'b0, 8'h5a);
        chk("R4 empty after first write", 400, 32'(empty), 0);
        chk("R4 head visible", 400, 32'(rd_data), 32'h5a);
        step(1'b1, 1'b0, 8'h6b);
        chk("R4 head held", 401, 32'(rd_data), 32'h5a);
        step(1'b0, 1'b1, 8'h00);
        chk("R4 next word", 402, 32'(rd_data), 32'h6b);
        chk("R4 not empty", 402, 32'(empty), 0);
        step(1'b0, 1'b1, 8'h00);
        chk("R4 empty", 403, 32'(empty), 1);
        step(1'b1, 1'b1, 8'h7c);
        chk("R9 write kept", 404, 32'(empty), 0);
        chk("R9 underflow", 404, 32'(underflow), 1);
        chk("R9 head", 404, 32'(rd_data), 32'h7c);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule